// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns a parallel RGB pixel stream into the serial bit streams that feed a set of differential transmit pads. It runs on a fast clock at seven times the pixel rate. A one-in-seven load strobe tells it where each pixel period begins. On every strobe it captures one pixel, or two pixels in dual mode, together with horizontal sync, vertical sync and data enable. Each data lane then sends seven bits, one per fast clock cycle, with the highest slot first. A clock lane sends a fixed seven-bit pattern aligned to the same boundary.

Three packings are available. The narrow mode sends six bits per colour on three lanes, which is 21 bits per period. The wide mode sends eight bits per colour on four lanes, which is 28 bits per period. The dual mode sends an even pixel on channel A and an odd pixel on channel B, each with the wide packing, which is 56 bits per period. A downstream pad ring turns each single-ended output bit into a differential pair. Channel B has its own clock lane, so the receiver of each channel sees half the total pixel rate.

Top module: `lvds7_serializer`

## Requirements
- R1: After a strobe, each lane emits seven bits over the next seven fast cycles, slot 6 first and slot 0 last. Clock lane A emits 1,1,0,0,0,1,1 in that order, starting in the cycle after the strobe.
- R2: Pixel bits are red [23:16], green [15:8] and blue [7:0]. In slot order 6 to 0, lane 0 carries R7..R2 then G7. Lane 1 carries G6..G2, B7, B6. Lane 2 carries B5..B2, then hsync, vsync and data enable.
- R3: In wide mode (mode 01), lane 3 carries R1, R0, G1, G0, B1, B0 and then a spare control slot that is always 0.
- R4: In narrow mode (mode 00), lane 3 stays low for the whole period. The two least significant bits of each colour do not appear on any lane.
- R5: In dual mode (mode 10), channel A (data_lane_o[3:0]) carries the even pixel and channel B (data_lane_o[7:4]) carries the odd pixel. Both use the R2/R3 map and both carry the same sync and enable bits. Clock lane B repeats the same pattern as clock lane A.
- R6: In any mode other than dual, all channel B data lanes and clock lane B stay low for that period.
- R7: Pixel, control and mode inputs are sampled only on the strobe. Changing them between strobes leaves the period in flight unchanged.
- R8: While reset is asserted, and after it is released until the first strobe, every output is low.
- R9: Mode 11 behaves exactly like wide mode.
- R10: With no further strobe, the clock lanes keep repeating their pattern every seven cycles, and the data lanes go low once slot 0 has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | One-cycle strobe that marks the start of a pixel period |
| mode_i | input | 2 | Packing: 00 narrow, 01 wide, 10 dual, 11 wide |
| pix_even_i | input | 24 | Pixel for channel A (the even pixel in dual mode) |
| pix_odd_i | input | 24 | Odd pixel for channel B (used in dual mode only) |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| data_lane_o | output | 8 | Serial data lanes: [3:0] channel A, [7:4] channel B |
| clk_lane_o | output | 2 | Clock lanes: [0] channel A, [1] channel B |

## Verification
The hardest situation to reach from the ports is a change to the inputs while a word is still shifting out. With a steady strobe, every input change happens to coincide with a load. The bench therefore uses one scenario that rewrites the pixels, the control bits and the mode in the cycle right after the strobe, then collects all seven slots and compares them with the word captured at the strobe. A second hard case is the switch from dual mode back to a single-channel mode, which must silence channel B at exactly the next boundary. The bench drives a dual period followed at once by a wide period to reach it. A period with no strobe at all shows that the clock lanes keep running while the data lanes drain to zero.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
   typedef enum logic [1:0] {
      PACK_NARROW = 2'b00,
      PACK_WIDE   = 2'b01,
      PACK_DUAL   = 2'b10,
      PACK_SPARE  = 2'b11
   } pack_mode_e;

   localparam int unsigned SLOT_N = 7;
   localparam logic [SLOT_N-1:0] CLK_SHAPE = 7'b1100011;
endpackage

// File: rtl/lvds7_slot_map.sv
module lvds7_slot_map #(
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned KEEP_W  = 6,
   parameter int unsigned SLOTS   = 7,
   parameter int unsigned LANES   = 4,
   localparam int unsigned PIX_W  = 3 * COLOR_W,
   localparam int unsigned LOW_W  = COLOR_W - KEEP_W,
   localparam int unsigned CORE_W = 3 * KEEP_W + 3,
   localparam int unsigned EXT_W  = 3 * LOW_W + 1,
   localparam int unsigned WORD_W = LANES * SLOTS
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic              hs,
   input  logic              vs,
   input  logic              de,
   input  logic              wide,
   input  logic              en,
   output logic [WORD_W-1:0] word
);
   logic [COLOR_W-1:0] red, grn, blu;
   logic [CORE_W-1:0]  core;
   logic [EXT_W-1:0]   ext;

   assign red = pix[PIX_W-1 -: COLOR_W];
   assign grn = pix[2*COLOR_W-1 -: COLOR_W];
   assign blu = pix[COLOR_W-1:0];

   // upper colour bits, then sync/enable, fill lanes 0..2
   assign core = {red[COLOR_W-1 -: KEEP_W], grn[COLOR_W-1 -: KEEP_W],
                  blu[COLOR_W-1 -: KEEP_W], hs, vs, de};
   // colour LSBs plus the zero control pad on the last lane
   assign ext  = {red[LOW_W-1:0], grn[LOW_W-1:0], blu[LOW_W-1:0], 1'b0};

   always_comb begin
      word = '0;
      if (en) begin
         word[WORD_W-1 -: CORE_W] = core;
         if (wide) word[EXT_W-1:0] = ext;
      end
   end
endmodule

// File: rtl/lvds7_shifter.sv
module lvds7_shifter #(
   parameter int unsigned SLOTS  = 7,
   parameter bit          ROTATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SLOTS-1:0] word,
   output logic             bit_o
);
   logic [SLOTS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= word;
      else           sh_q <= {sh_q[SLOTS-2:0], ROTATE ? sh_q[SLOTS-1] : 1'b0};
   end

   assign bit_o = sh_q[SLOTS-1];
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer
   import lvds7_pkg::*;
#(
   parameter int unsigned COLOR_W    = 8,
   parameter int unsigned KEEP_W     = 6,
   parameter int unsigned DATA_LANES = 4,
   parameter int unsigned CHANNELS   = 2,
   localparam int unsigned PIX_W     = 3 * COLOR_W,
   localparam int unsigned WORD_W    = DATA_LANES * SLOT_N,
   localparam int unsigned OUT_W     = DATA_LANES * CHANNELS
) (
   input  logic                clk_ser,
   input  logic                rst_n,
   input  logic                load_stb,
   input  logic [1:0]          mode_i,
   input  logic [PIX_W-1:0]    pix_even_i,
   input  logic [PIX_W-1:0]    pix_odd_i,
   input  logic                hsync_i,
   input  logic                vsync_i,
   input  logic                de_i,
   output logic [OUT_W-1:0]    data_lane_o,
   output logic [CHANNELS-1:0] clk_lane_o
);
   if (3 * KEEP_W + 3 != 3 * SLOT_N) begin : g_bad_core
      $error("narrow packing must fill exactly three lanes");
   end
   if (3 * (COLOR_W - KEEP_W) + 1 != SLOT_N) begin : g_bad_ext
      $error("colour LSBs plus pad must fill exactly one lane");
   end
   if (DATA_LANES != 4 || CHANNELS != 2) begin : g_bad_lanes
      $error("four lanes per channel and two channels are required");
   end

   pack_mode_e mode;
   logic       dual, wide;

   assign mode = pack_mode_e'(mode_i);
   assign dual = (mode == PACK_DUAL);
   assign wide = (mode != PACK_NARROW);

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      logic [WORD_W-1:0] word;
      logic              ch_en;

      assign ch_en = (ch == 0) ? 1'b1 : dual;

      lvds7_slot_map #(
         .COLOR_W(COLOR_W), .KEEP_W(KEEP_W), .SLOTS(SLOT_N), .LANES(DATA_LANES)
      ) u_map (
         .pix  ((ch == 0) ? pix_even_i : pix_odd_i),
         .hs   (hsync_i),
         .vs   (vsync_i),
         .de   (de_i),
         .wide (wide),
         .en   (ch_en),
         .word (word)
      );

      for (genvar ln = 0; ln < DATA_LANES; ln++) begin : g_ln
         lvds7_shifter #(.SLOTS(SLOT_N), .ROTATE(1'b0)) u_sh (
            .clk   (clk_ser),
            .rst_n (rst_n),
            .load  (load_stb),
            .word  (word[WORD_W-1-ln*SLOT_N -: SLOT_N]),
            .bit_o (data_lane_o[ch*DATA_LANES+ln])
         );
      end

      lvds7_shifter #(.SLOTS(SLOT_N), .ROTATE(1'b1)) u_clk (
         .clk   (clk_ser),
         .rst_n (rst_n),
         .load  (load_stb),
         .word  (ch_en ? CLK_SHAPE : '0),
         .bit_o (clk_lane_o[ch])
      );
   end
endmodule

// File: rtl/lvds7_checks.sv
module lvds7_checks (
   input logic       clk_ser,
   input logic       rst_n,
   input logic       load_stb,
   input logic [1:0] mode_i,
   input logic       even_msb,
   input logic       odd_msb,
   input logic [7:0] data_lane_o,
   input logic [1:0] clk_lane_o
);
   always @(posedge clk_ser) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (data_lane_o == '0 && clk_lane_o == '0); // R8
      end
   end

   AST_CLK_FIRST: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb |=> clk_lane_o[0]); // R1
   AST_CLK_SECOND: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb ##1 !load_stb |=> clk_lane_o[0]); // R1
   AST_CLK_THIRD: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb ##1 !load_stb ##1 !load_stb |=> !clk_lane_o[0]); // R1
   AST_TOP_SLOT: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb |=> data_lane_o[0] == $past(even_msb)); // R2
   AST_NARROW_LANE3: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb && mode_i == 2'b00 |=> !data_lane_o[3]); // R4
   AST_DUAL_B: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb && mode_i == 2'b10 |=> clk_lane_o[1] && data_lane_o[4] == $past(odd_msb)); // R5
   AST_B_QUIET: assert property (@(posedge clk_ser) disable iff (!rst_n)
      load_stb && mode_i != 2'b10 |=> data_lane_o[7:4] == 4'b0 && !clk_lane_o[1]); // R6
endmodule

bind lvds7_serializer lvds7_checks u_checks (
   .clk_ser     (clk_ser),
   .rst_n       (rst_n),
   .load_stb    (load_stb),
   .mode_i      (mode_i),
   .even_msb    (pix_even_i[23]),
   .odd_msb     (pix_odd_i[23]),
   .data_lane_o (data_lane_o),
   .clk_lane_o  (clk_lane_o)
);

// File: tb/lvds7_serializer_bench.sv
module lvds7_serializer_bench;
   logic        clk_ser = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_stb = 1'b0;
   logic [1:0]  mode_i = 2'b01;
   logic [23:0] pix_even_i = '0;
   logic [23:0] pix_odd_i = '0;
   logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
   logic [7:0]  data_lane_o;
   logic [1:0]  clk_lane_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk_ser = ~clk_ser;

   lvds7_serializer u_lvds7_serializer (
      .clk_ser(clk_ser), .rst_n(rst_n), .load_stb(load_stb), .mode_i(mode_i),
      .pix_even_i(pix_even_i), .pix_odd_i(pix_odd_i),
      .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
      .data_lane_o(data_lane_o), .clk_lane_o(clk_lane_o)
   );

   task automatic check(string req, string what, logic [13:0] act, logic [13:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] lane_exp(logic [23:0] p, logic hs, logic vs,
                                           logic de, int ln, bit wide);
      logic [7:0] r, g, b;
      r = p[23:16]; g = p[15:8]; b = p[7:0];
      case (ln)
         0:       return {r[7], r[6], r[5], r[4], r[3], r[2], g[7]};
         1:       return {g[6], g[5], g[4], g[3], g[2], b[7], b[6]};
         2:       return {b[5], b[4], b[3], b[2], hs, vs, de};
         default: return wide ? {r[1], r[0], g[1], g[0], b[1], b[0], 1'b0} : 7'b0;
      endcase
   endfunction

   // Called just after a falling edge; leaves the bench just after the falling edge of slot 0.
   task automatic run_pixel(string tag, logic [1:0] md, logic [23:0] pa, logic [23:0] pb,
                            logic hs, logic vs, logic de, bit disturb);
      logic [6:0] got [8];
      logic [6:0] ck [2];
      bit dual, wide;
      dual = (md == 2'b10);
      wide = (md != 2'b00);
      mode_i = md; pix_even_i = pa; pix_odd_i = pb;
      hsync_i = hs; vsync_i = vs; de_i = de;
      load_stb = 1'b1;
      for (int k = 0; k < 8; k++) got[k] = '0;
      ck[0] = '0; ck[1] = '0;
      for (int s = 0; s < 7; s++) begin
         @(negedge clk_ser);
         load_stb = 1'b0;
         for (int k = 0; k < 8; k++) got[k] = {got[k][5:0], data_lane_o[k]};
         ck[0] = {ck[0][5:0], clk_lane_o[0]};
         ck[1] = {ck[1][5:0], clk_lane_o[1]};
         if (disturb && s == 0) begin
            // R7: rewrite everything mid-period
            pix_even_i = ~pa; pix_odd_i = ~pb; mode_i = ~md;
            hsync_i = ~hs; vsync_i = ~vs; de_i = ~de;
         end
      end
      check({tag, "/R1"}, "clock lane A", {7'b0, ck[0]}, {7'b0, 7'b1100011});
      for (int ln = 0; ln < 4; ln++) begin
         check({tag, (ln == 3) ? (wide ? "/R3" : "/R4") : "/R2"}, $sformatf("ch A lane %0d", ln),
               {7'b0, got[ln]}, {7'b0, lane_exp(pa, hs, vs, de, ln, wide)});
         check({tag, dual ? "/R5" : "/R6"}, $sformatf("ch B lane %0d", ln),
               {7'b0, got[4+ln]}, {7'b0, dual ? lane_exp(pb, hs, vs, de, ln, 1'b1) : 7'b0});
      end
      check({tag, dual ? "/R5" : "/R6"}, "clock lane B", {7'b0, ck[1]},
            {7'b0, dual ? 7'b1100011 : 7'b0});
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk_ser);
      check("R8", "outputs in reset", {4'b0, data_lane_o, clk_lane_o}, 14'b0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk_ser);
         check("R8", "outputs before first strobe", {4'b0, data_lane_o, clk_lane_o}, 14'b0);
      end
   endtask

   task automatic t_idle();
      logic [13:0] ck2;
      logic [7:0]  anyd;
      ck2 = '0; anyd = '0;
      for (int s = 0; s < 14; s++) begin
         @(negedge clk_ser);
         ck2 = {ck2[12:0], clk_lane_o[0]};
         anyd |= data_lane_o;
      end
      check("R10", "free-running clock lane A", ck2, {7'b1100011, 7'b1100011});
      check("R10", "data lanes drained", {6'b0, anyd}, 14'b0);
   endtask

   initial begin
      t_reset();
      run_pixel("wide", 2'b01, 24'hA5C31E, 24'h0, 1'b1, 1'b0, 1'b1, 1'b0);
      run_pixel("wide", 2'b01, 24'h3C5A96, 24'h0, 1'b0, 1'b1, 1'b0, 1'b0);
      run_pixel("R4", 2'b00, 24'hFFFFFF, 24'hFFFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
      run_pixel("R4", 2'b00, 24'h814203, 24'h0, 1'b1, 1'b1, 1'b0, 1'b0);
      run_pixel("R5", 2'b10, 24'h12F0A7, 24'hED0F58, 1'b1, 1'b0, 1'b1, 1'b0);
      run_pixel("R6", 2'b01, 24'h00FF00, 24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
      run_pixel("R9", 2'b11, 24'h5A3CC3, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
      run_pixel("R7", 2'b10, 24'hC0FFEE, 24'h0BADF0, 1'b1, 1'b0, 1'b0, 1'b1);
      run_pixel("R7", 2'b00, 24'h6699CC, 24'h0, 1'b0, 1'b1, 1'b1, 1'b1);
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_ser);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule